// File: doc/BRIEF.md
# Byte-Serial SPI Master with Staged Bus Release

This block is a single-lane SPI master. A request carries one byte to send, a clock-phase choice, a chip-select index and two framing flags. The byte goes out most significant bit first, one bit per bit period, while the serial input is captured into a receive byte. Each bit period is split into a setup part and a hold part, and the length of each part is fixed by a parameter. When the last bit is done, the received byte comes back with a one-cycle pulse. The clock, data-out and chip-select pads each have their own output enable, and a pin-ownership flag tells the pad ring that the block is driving them.

A frame opens on the first request that arrives while no frame is active. A begin flag with a valid index selects one chip-select line. The frame stays open across later requests until one of them carries the end flag. The bus is then let go in a fixed order. The select line drops while the clock pad is still driven. Then the clock enable turns off. A run-time delay follows, and after it every pad is released.

Top module: `spi_stage_master`

## Requirements
- R1: A byte is shifted in 8 bit periods, most significant bit first. Each period lasts SETUP_CYC + HOLD_CYC clocks: SETUP_CYC clocks at the first clock level, then HOLD_CYC clocks at the second level.
- R2: The first level is sck = req_cpha and the second level is sck = !req_cpha. While a frame is open and no bit is moving, sck rests at the second level.
- R3: sdo takes the bit at the start of each bit period and holds it for the whole period. With req_tx_en = 0, sdo is 0 for every bit.
- R4: sdi is sampled in the last clock of each bit period. The first sampled bit becomes bit 7 of rx_byte. In the clock after the last bit period, rx_valid is high for exactly one cycle with rx_byte valid.
- R5: A request accepted while no frame is active first gives one activation cycle: pin_own, sck_oe and sdo_oe high, chip select applied, sck at the second level and sdo = 0. The first bit period follows.
- R6: At activation, req_begin = 1 with req_cs_en = 1 sets bit req_cs_idx of both cs_sel and cs_oe (cs_sel = 1 means selected), and no other bit. With req_cs_en = 0, or with req_begin = 0, no chip-select bit is set.
- R7: A request accepted while a frame is open has no activation cycle. Its phase, begin flag and chip-select fields are ignored, and the frame's phase and chip select stay in force.
- R8: After a byte without req_end, the frame stays open. pin_own, the enables and cs_sel stay driven, sdo keeps the last bit sent, and req_ready returns high.
- R9: After a byte with req_end, the bus is released in this order. First, HOLD_CYC clocks with cs_sel = 0 while cs_oe, sck_oe and sdo_oe stay high and sck stays at the second level. Next, one clock with sck_oe = 0. Then desel_dly clocks in the same state (skipped when desel_dly = 0). After that, every output is 0 and req_ready is 1.
- R10: req_ready is high exactly when no byte is moving and no release is in progress. A request is taken on a clock where req_valid and req_ready are both high.
- R11: After reset all pad outputs and enables are 0, rx_valid is 0 and req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_tx | input | 8 | Byte to send |
| req_tx_en | input | 1 | 1: send req_tx; 0: send zeros |
| req_cpha | input | 1 | Clock phase; first-level sck value |
| req_cs_en | input | 1 | A chip-select index is given |
| req_cs_idx | input | CS_IDX_W | Chip-select line number |
| req_begin | input | 1 | Begin-of-frame flag |
| req_end | input | 1 | End-of-frame flag |
| desel_dly | input | DLY_W | Deselect delay in clocks, read when a request is taken |
| rx_valid | output | 1 | One-cycle pulse, received byte ready |
| rx_byte | output | 8 | Received byte |
| sdi | input | 1 | Serial data in |
| pin_own | output | 1 | Block owns the SPI pads |
| sck | output | 1 | Serial clock level |
| sck_oe | output | 1 | Serial clock output enable |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Serial data output enable |
| cs_sel | output | CS_W | Chip-select levels, 1 = selected |
| cs_oe | output | CS_W | Chip-select output enables |

## Verification
The bench drives alternating, edge-only (0x81) and random bytes out and opposite patterns in. This shows whether the bit order is reversed or shifted by one in each direction. Both clock phases are run, and that splits a swapped first and second level from a correct one. Frames of one, two and three bytes check that activation runs once per frame and that late begin flags and chip-select fields have no effect. Release is run with a delay of zero and with non-zero delays, and every clock of each stage is compared, so a dropped, reordered or lengthened stage shows up.

// File: rtl/spi_stage_pkg.sv
package spi_stage_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ACT,
      ST_PH1,
      ST_PH2,
      ST_REL_CS,
      ST_REL_SCK,
      ST_REL_DLY
   } stage_e;

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/spi_stage_timer.sv
module spi_stage_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   output logic [CW-1:0] count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (restart)
         count <= '0;
      else if (count != {CW{1'b1}})
         count <= count + 1'b1;
   end
endmodule

// File: rtl/spi_stage_shifter.sv
module spi_stage_shifter #(
   parameter int BW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [BW-1:0] load_byte,
   input  logic          load_en,
   input  logic          step,
   input  logic          sdi,
   output logic          tx_msb,
   output logic [BW-1:0] rx_next
);
   logic [BW-1:0] tx_q;
   logic [BW-1:0] rx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q <= '0;
         rx_q <= '0;
      end else if (load) begin
         tx_q <= load_en ? load_byte : '0;
         rx_q <= '0;
      end else if (step) begin
         tx_q <= {tx_q[BW-2:0], 1'b0};
         rx_q <= rx_next;
      end
   end

   assign tx_msb  = tx_q[BW-1];
   assign rx_next = {rx_q[BW-2:0], sdi};
endmodule

// File: rtl/spi_stage_csdec.sv
module spi_stage_csdec #(
   parameter int CS_W     = 4,
   parameter int CS_IDX_W = 2
) (
   input  logic                enable,
   input  logic [CS_IDX_W-1:0] idx,
   output logic [CS_W-1:0]     mask
);
   for (genvar i = 0; i < CS_W; i++) begin : g_line
      assign mask[i] = enable && (idx == CS_IDX_W'(i));
   end
endmodule

// File: rtl/spi_stage_master.sv
module spi_stage_master
   import spi_stage_pkg::*;
#(
   parameter int CS_W      = 4,
   parameter int SETUP_CYC = 2,
   parameter int HOLD_CYC  = 2,
   parameter int DLY_W     = 8,
   localparam int CS_IDX_W = (CS_W > 1) ? $clog2(CS_W) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic [7:0]          req_tx,
   input  logic                req_tx_en,
   input  logic                req_cpha,
   input  logic                req_cs_en,
   input  logic [CS_IDX_W-1:0] req_cs_idx,
   input  logic                req_begin,
   input  logic                req_end,
   input  logic [DLY_W-1:0]    desel_dly,
   output logic                rx_valid,
   output logic [7:0]          rx_byte,
   input  logic                sdi,
   output logic                pin_own,
   output logic                sck,
   output logic                sck_oe,
   output logic                sdo,
   output logic                sdo_oe,
   output logic [CS_W-1:0]     cs_sel,
   output logic [CS_W-1:0]     cs_oe
);
   localparam int BW   = 8;
   localparam int TW   = $clog2(max_of(SETUP_CYC, HOLD_CYC) + 1);
   localparam int CW   = DLY_W + TW;
   localparam logic [CW-1:0] SETUP_LAST = CW'(SETUP_CYC - 1);
   localparam logic [CW-1:0] HOLD_LAST  = CW'(HOLD_CYC - 1);

   if (CS_W < 2) begin : g_bad_cs
      $error("CS_W must be at least 2");
   end
   if (SETUP_CYC < 1) begin : g_bad_setup
      $error("SETUP_CYC must be at least 1");
   end
   if (HOLD_CYC < 1) begin : g_bad_hold
      $error("HOLD_CYC must be at least 1");
   end
   if (DLY_W < 1) begin : g_bad_dly
      $error("DLY_W must be at least 1");
   end

   stage_e            state, state_nxt;
   logic              active_q, cpha_q, end_q, sdo_last_q;
   logic [CS_W-1:0]   mask_q, dec_mask;
   logic [2:0]        bit_q;
   logic [DLY_W-1:0]  dly_q;
   logic [CW-1:0]     cnt;
   logic              accept, setup_done, hold_done, dly_done, last_bit;
   logic              step, tx_msb, releasing, sck_off;
   logic [BW-1:0]     rx_next;

   assign req_ready  = (state == ST_IDLE);
   assign accept     = req_valid && req_ready;
   assign setup_done = (cnt == SETUP_LAST);
   assign hold_done  = (cnt == HOLD_LAST);
   assign dly_done   = ((cnt + 1'b1) == {{TW{1'b0}}, dly_q});
   assign last_bit   = (bit_q == 3'd0);
   assign step       = (state == ST_PH2) && hold_done;

   spi_stage_timer #(.CW(CW)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (state_nxt != state),
      .count   (cnt)
   );

   spi_stage_shifter #(.BW(BW)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .load_byte (req_tx),
      .load_en   (req_tx_en),
      .step      (step),
      .sdi       (sdi),
      .tx_msb    (tx_msb),
      .rx_next   (rx_next)
   );

   spi_stage_csdec #(.CS_W(CS_W), .CS_IDX_W(CS_IDX_W)) u_csdec (
      .enable (req_cs_en && req_begin),
      .idx    (req_cs_idx),
      .mask   (dec_mask)
   );

   always_comb begin
      state_nxt = state;
      unique case (state)
         ST_IDLE:    if (accept) state_nxt = active_q ? ST_PH1 : ST_ACT;
         ST_ACT:     state_nxt = ST_PH1;
         ST_PH1:     if (setup_done) state_nxt = ST_PH2;
         ST_PH2:     if (hold_done) begin
                        if (!last_bit)  state_nxt = ST_PH1;
                        else if (end_q) state_nxt = ST_REL_CS;
                        else            state_nxt = ST_IDLE;
                     end
         ST_REL_CS:  if (hold_done) state_nxt = ST_REL_SCK;
         ST_REL_SCK: state_nxt = (dly_q == '0) ? ST_IDLE : ST_REL_DLY;
         ST_REL_DLY: if (dly_done) state_nxt = ST_IDLE;
         default:    state_nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         active_q   <= 1'b0;
         cpha_q     <= 1'b0;
         mask_q     <= '0;
         end_q      <= 1'b0;
         bit_q      <= '0;
         dly_q      <= '0;
         sdo_last_q <= 1'b0;
         rx_valid   <= 1'b0;
         rx_byte    <= '0;
      end else begin
         state    <= state_nxt;
         rx_valid <= step && last_bit;
         if (accept) begin
            end_q <= req_end;
            dly_q <= desel_dly;
            bit_q <= 3'd7;
            if (!active_q) begin
               active_q   <= 1'b1;
               cpha_q     <= req_cpha;
               mask_q     <= dec_mask;
               sdo_last_q <= 1'b0;
            end
         end
         if (step) begin
            bit_q      <= bit_q - 1'b1;
            sdo_last_q <= tx_msb;
            if (last_bit) rx_byte <= rx_next;
         end
         if ((state == ST_REL_SCK || state == ST_REL_DLY) && state_nxt == ST_IDLE)
            active_q <= 1'b0;
      end
   end

   assign releasing = (state == ST_REL_CS) || sck_off;
   assign sck_off   = (state == ST_REL_SCK) || (state == ST_REL_DLY);

   always_comb begin
      pin_own = active_q;
      sdo_oe  = active_q;
      sck_oe  = active_q && !sck_off;
      cs_oe   = active_q ? mask_q : '0;
      cs_sel  = (active_q && !releasing) ? mask_q : '0;
      sck     = active_q ? ((state == ST_PH1) ? cpha_q : !cpha_q) : 1'b0;
      if (state == ST_PH1 || state == ST_PH2) sdo = tx_msb;
      else                                     sdo = active_q && sdo_last_q;
   end

   p_cs_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cs_sel) && $onehot0(cs_oe));

   p_cs_in_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_sel & ~cs_oe) == '0);

   p_sdo_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PH2) |-> $stable(sdo));

   p_rx_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   p_sck_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_REL_CS && $past(state) == ST_PH2) |-> ($stable(sck) && sck_oe));

   p_sckoe_after_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(sck_oe) && pin_own) |-> (cs_sel == '0 && $past(cs_sel) == '0));

   p_own_after_sckoe_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pin_own) |-> $past(!sck_oe));

   p_ready_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && !pin_own) |-> (!sck_oe && cs_oe == '0 && !sdo_oe));
endmodule

// File: tb/tb_spi_stage_master.sv
module tb_spi_stage_master;
   localparam int CS_W  = 4;
   localparam int SETUP = 2;
   localparam int HOLD  = 2;
   localparam int DLY_W = 8;
   localparam int IW    = 2;
   localparam int P     = SETUP + HOLD;
   localparam int VW    = 7 + 2 * CS_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_ready;
   logic [7:0] req_tx = '0;
   logic req_tx_en = 1'b0, req_cpha = 1'b0, req_cs_en = 1'b0;
   logic [IW-1:0] req_cs_idx = '0;
   logic req_begin = 1'b0, req_end = 1'b0;
   logic [DLY_W-1:0] desel_dly = '0;
   logic rx_valid;
   logic [7:0] rx_byte;
   logic sdi = 1'b0;
   logic pin_own, sck, sck_oe, sdo, sdo_oe;
   logic [CS_W-1:0] cs_sel, cs_oe;

   int vectors = 0;
   int errors  = 0;
   bit finished = 1'b0;

   bit              m_active = 1'b0;
   bit              m_cpha   = 1'b0;
   logic [CS_W-1:0] m_mask   = '0;
   bit              m_sdo    = 1'b0;

   always #5 clk = ~clk;

   spi_stage_master #(.CS_W(CS_W), .SETUP_CYC(SETUP), .HOLD_CYC(HOLD), .DLY_W(DLY_W)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_tx(req_tx), .req_tx_en(req_tx_en), .req_cpha(req_cpha), .req_cs_en(req_cs_en),
      .req_cs_idx(req_cs_idx), .req_begin(req_begin), .req_end(req_end),
      .desel_dly(desel_dly), .rx_valid(rx_valid), .rx_byte(rx_byte), .sdi(sdi),
      .pin_own(pin_own), .sck(sck), .sck_oe(sck_oe), .sdo(sdo), .sdo_oe(sdo_oe),
      .cs_sel(cs_sel), .cs_oe(cs_oe)
   );

   wire [VW-1:0] got_vec = {pin_own, sck_oe, sck, sdo_oe, sdo, cs_oe, cs_sel, rx_valid, req_ready};

   function automatic logic [VW-1:0] pack(input bit own, input bit so, input bit sk,
                                          input bit doe, input bit d,
                                          input logic [CS_W-1:0] coe, input logic [CS_W-1:0] csel,
                                          input bit rv, input bit rdy);
      return {own, so, sk, doe, d, coe, csel, rv, rdy};
   endfunction

   task automatic check_vec(input logic [VW-1:0] exp, input string tag, input int k);
      vectors++;
      if (got_vec !== exp) begin
         errors++;
         $display("FAIL %s cycle %0d: got %b expected %b", tag, k, got_vec, exp);
      end
   endtask

   // One byte request; the bench model follows R1..R10 to predict each cycle.
   task automatic xfer(input logic [7:0] d, input bit tx_en, input bit cpha, input bit cs_en,
                       input int idx, input bit beg, input bit en, input logic [7:0] sdi_b,
                       input int dly, input string tag);
      bit act;
      int k0, k;
      bit done;
      bit clk1, clk2;
      act = !m_active;
      if (act) begin
         m_active = 1'b1;
         m_cpha   = cpha;
         m_mask   = (beg && cs_en) ? CS_W'(1 << idx) : '0; // R6
         m_sdo    = 1'b0;
      end
      clk1 = m_cpha;   // R2
      clk2 = !m_cpha;
      k0 = act ? 2 : 1;
      @(negedge clk);
      req_valid = 1'b1; req_tx = d; req_tx_en = tx_en; req_cpha = cpha;
      req_cs_en = cs_en; req_cs_idx = IW'(idx); req_begin = beg; req_end = en;
      desel_dly = DLY_W'(dly);
      k = 0;
      done = 1'b0;
      while (!done) begin
         @(negedge clk);
         k++;
         req_valid = 1'b0;
         if (act && k == 1) begin
            check_vec(pack(1, 1, clk2, 1, 0, m_mask, m_mask, 0, 0), {tag, " R5 activation"}, k);
         end else if (k < k0 + 8 * P) begin
            int b, ph;
            bit bitv;
            b = (k - k0) / P;
            ph = (k - k0) % P;
            if (ph == 0) sdi = sdi_b[7 - b];
            bitv = tx_en && d[7 - b];
            check_vec(pack(1, 1, (ph < SETUP) ? clk1 : clk2, 1, bitv, m_mask, m_mask, 0, 0),
                      {tag, " R1 R2 R3 bit"}, k);
            if (b == 7 && ph == P - 1) m_sdo = tx_en && d[0];
         end else begin
            int r;
            r = k - (k0 + 8 * P);
            if (r == 0) begin
               vectors++;
               if (rx_byte !== sdi_b) begin
                  errors++;
                  $display("FAIL %s R4 rx_byte: got %h expected %h", tag, rx_byte, sdi_b);
               end
            end
            if (!en) begin
               check_vec(pack(1, 1, clk2, 1, m_sdo, m_mask, m_mask, r == 0, 1), {tag, " R8 R10 open"}, k);
               done = 1'b1;
            end else if (r < HOLD) begin
               check_vec(pack(1, 1, clk2, 1, m_sdo, m_mask, '0, r == 0, 0), {tag, " R9 cs drop"}, k);
            end else if (r <= HOLD + dly) begin
               check_vec(pack(1, 0, clk2, 1, m_sdo, m_mask, '0, 0, 0), {tag, " R9 sck off"}, k);
            end else begin
               check_vec(pack(0, 0, 0, 0, 0, '0, '0, 0, 1), {tag, " R9 R10 released"}, k);
               m_active = 1'b0;
               done = 1'b1;
            end
         end
      end
   endtask

   initial begin
      repeat (2000 * 60) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R11: reset state
      check_vec(pack(0, 0, 0, 0, 0, '0, '0, 0, 1), "R11 in reset", 0);
      rst_n = 1'b1;
      @(negedge clk);
      check_vec(pack(0, 0, 0, 0, 0, '0, '0, 0, 1), "R11 after reset", 0);

      // Directed: single-byte frames, both phases, zero and non-zero delay
      xfer(8'hA5, 1, 0, 1, 2, 1, 1, 8'h3C, 0, "cpha0 cs2");
      xfer(8'h81, 1, 1, 1, 0, 1, 1, 8'h7E, 3, "cpha1 cs0");
      // R7: second begin with other cs/cpha inside an open frame is ignored
      xfer(8'h5A, 1, 0, 1, 1, 1, 0, 8'hC3, 0, "R7 frame b0");
      xfer(8'hF0, 1, 1, 1, 3, 1, 0, 8'h0F, 0, "R7 frame b1");
      xfer(8'h01, 1, 1, 1, 0, 0, 1, 8'h80, 2, "R7 frame b2");
      // R3: no transmit data drives zeros
      xfer(8'hFF, 0, 1, 1, 3, 1, 1, 8'hFF, 1, "R3 no tx");
      // R6: begin without an index, and no begin while inactive
      xfer(8'h96, 1, 0, 0, 1, 1, 1, 8'h69, 0, "R6 no index");
      xfer(8'h3C, 1, 1, 1, 1, 0, 1, 8'h55, 0, "R6 no begin");

      // Random frames of 1..3 bytes
      for (int f = 0; f < 30; f++) begin
         int n, dly, idx;
         bit cpha, cs_en;
         n     = $urandom_range(1, 3);
         dly   = $urandom_range(0, 4);
         idx   = $urandom_range(0, CS_W - 1);
         cpha  = 1'($urandom_range(0, 1));
         cs_en = ($urandom_range(0, 3) != 0);
         for (int i = 0; i < n; i++) begin
            xfer(8'($urandom), 1'($urandom_range(0, 7) != 0), cpha, cs_en, idx,
                 (i == 0) || ($urandom_range(0, 1) == 1), i == n - 1, 8'($urandom), dly, "random");
            if ($urandom_range(0, 1) == 1) begin
               repeat ($urandom_range(1, 3)) @(negedge clk);
            end
         end
      end

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule